// File: doc/BRIEF.md
# Prefetch Read Serializer with CAS Latency

This block is the read data path behind a 4n-prefetch double-data-rate memory core. Each internal core access hands it one 128-bit word. The block holds that word for a programmable CAS latency. It then drives the word out as four 32-bit beats on consecutive half-clock slots: two beats per clock cycle, one for each half of the cycle.

The double-rate output is modelled at the block clock. In every cycle the beat for the first half appears on `dq_rise` and the beat for the second half appears on `dq_fall`. A flag marks cycles that carry data. A per-byte-lane strobe level, `rdqs_hi`, is high in the first half of each data cycle and low in the second half. This places a strobe edge exactly on every beat boundary.

A read command selects a burst of 4 or a burst of 8. A burst of 8 takes the core word present with the command and then a second core word on the next cycle. The two words leave as eight gap-free beats. Commands spaced at their burst length produce an unbroken output stream. The CAS latency is captured with each command.

Top module: `prefetch_rd_serializer`

## Requirements
- R1: While `rst_n` is low and after its release, before any command, `dq_vld`, `dq_rise`, `dq_fall` and `rdqs_hi` are all zero.
- R2: For a command sampled at clock edge E with a latency setting of L in the range 7 to 17, `dq_vld` is first high after edge E+L.
- R3: Beat order is least significant first. In the first data cycle `dq_rise` carries word bits 31:0 and `dq_fall` carries bits 63:32. In the second data cycle they carry bits 95:64 and 127:96.
- R4: A burst-of-4 command (`rd_bl8`=0) gives exactly two consecutive cycles with `dq_vld` high.
- R5: A burst-of-8 command (`rd_bl8`=1) takes `core_word` in its own cycle and again in the following cycle. It gives four consecutive data cycles, first word then second word, each ordered as in R3.
- R6: Burst-of-4 commands every 2 cycles, or burst-of-8 commands every 4 cycles, at the same latency give `dq_vld` high with no idle cycle between bursts.
- R7: `rdqs_hi` is 4'b1111 in every cycle where `dq_vld` is high and 4'b0000 in every other cycle.
- R8: In every cycle where `dq_vld` is low, `dq_rise` and `dq_fall` are zero.
- R9: A latency setting below 7 acts as 7, and a setting above 17 acts as 17.
- R10: `rd_cmd` in the cycle that takes the second word of a burst of 8 is ignored and adds no beats.
- R11: The latency is captured when the command is accepted. A change of `cas_lat` in the second-word cycle does not move the second word's beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one cycle carries two beats |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | Read command; the core word is present in the same cycle |
| rd_bl8 | input | 1 | Burst length select with the command: 0 = 4 beats, 1 = 8 beats |
| cas_lat | input | 5 | CAS latency in cycles, used in the range 7 to 17 |
| core_word | input | 128 | Prefetched core word |
| dq_rise | output | 32 | Beat for the first half of the cycle |
| dq_fall | output | 32 | Beat for the second half of the cycle |
| dq_vld | output | 1 | High when the cycle carries beats |
| rdqs_hi | output | 4 | Per-lane strobe level in the first half-cycle (low in the second) |

## Verification
The bench builds the block with its default limits of 7 and 17 on a 5-bit latency input. This puts every legal latency within reach, along with clamped settings such as 0 and 31 on either side. The bench predicts a beat schedule from each command and compares data, flag and strobe in every cycle. This catches off-by-one latency, swapped beat order, gaps in back-to-back trains and any stray beat from an ignored command. Random trains mix both burst lengths and latencies from 4 to 20 between directed corner cases.

// File: rtl/pfs_pkg.sv
`timescale 1ns/1ps
package pfs_pkg;
  localparam int BEAT_W = 32;
  localparam int HALF_W = 2 * BEAT_W;
  localparam int WORD_W = 4 * BEAT_W;
  localparam int LANES  = BEAT_W / 8;

  typedef struct packed {
    logic              vld;
    logic [HALF_W-1:0] pair;
  } slot_t;
endpackage

// File: rtl/pfs_cmd.sv
`timescale 1ns/1ps
// Command stage: clamps the latency, accepts commands and issues one
// ring write per core word (two for a burst of 8).
module pfs_cmd #(
  parameter int MIN_CL = 7,
  parameter int MAX_CL = 17,
  parameter int CLW    = 5,
  parameter int PW     = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_cmd,
  input  logic                       rd_bl8,
  input  logic [CLW-1:0]             cas_lat,
  input  logic [pfs_pkg::WORD_W-1:0] core_word,
  output logic                       wr_en,
  output logic [PW-1:0]              wr_dly,
  output logic [pfs_pkg::WORD_W-1:0] wr_word
);
  logic [CLW-1:0] cl_eff;
  logic           accept;
  logic           pend_q, pend_d;
  logic [PW-1:0]  dly2_q, dly2_d;

  always_comb begin
    cl_eff = cas_lat;
    if (cas_lat < CLW'(MIN_CL))      cl_eff = CLW'(MIN_CL);
    else if (cas_lat > CLW'(MAX_CL)) cl_eff = CLW'(MAX_CL);
  end

  // the cycle carrying the second word of a burst of 8 takes no command
  assign accept = rd_cmd & ~pend_q;

  always_comb begin
    pend_d = accept & rd_bl8;
    dly2_d = dly2_q;
    if (accept) dly2_d = PW'(cl_eff) + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly2_q <= '0;
    else if (accept) dly2_q <= dly2_d;
  end

  assign wr_en   = accept | pend_q;
  assign wr_dly  = pend_q ? dly2_q : PW'(cl_eff);
  assign wr_word = core_word;

  // R10: the second-word state lasts exactly one cycle
  a_r10_second_single: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);

  // R9: every write lands inside the clamped latency window
  a_r9_delay_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_dly >= PW'(MIN_CL) && wr_dly <= PW'(MAX_CL + 1)));

  // R5 / R11: the second word follows one cycle later with the captured latency
  a_r5_second_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rd_bl8) |=> (wr_en && wr_dly == PW'($past(cl_eff)) + PW'(1)));
endmodule

// File: rtl/pfs_ring.sv
`timescale 1ns/1ps
// Time-indexed slot ring: slot k holds the beat pair due k cycles after
// the read pointer. One word fills two adjacent slots.
module pfs_ring #(
  parameter int PW    = 5,
  parameter int SLOTS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PW-1:0]              wr_dly,
  input  logic [pfs_pkg::WORD_W-1:0] wr_word,
  output pfs_pkg::slot_t             rd_slot
);
  import pfs_pkg::*;

  logic [PW-1:0]     ptr_q, ptr_d;
  logic [PW-1:0]     idx_lo, idx_hi;
  logic [SLOTS-1:0]  vld_vec;
  logic [HALF_W-1:0] pair_arr [SLOTS];

  assign idx_lo = ptr_q + wr_dly;
  assign idx_hi = idx_lo + PW'(1);
  assign ptr_d  = ptr_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              hit_lo, hit_hi, vld_d, vld_r;
    logic [HALF_W-1:0] pair_r;

    assign hit_lo = wr_en && (idx_lo == PW'(s));
    assign hit_hi = wr_en && (idx_hi == PW'(s));
    // a slot is consumed when the pointer reads it
    assign vld_d  = hit_lo | hit_hi | (vld_r & (ptr_q != PW'(s)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_r <= 1'b0;
      else        vld_r <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (hit_lo)      pair_r <= wr_word[HALF_W-1:0];
      else if (hit_hi) pair_r <= wr_word[WORD_W-1:HALF_W];
    end

    assign vld_vec[s]  = vld_r;
    assign pair_arr[s] = pair_r;
  end

  assign rd_slot.vld  = vld_vec[ptr_q];
  assign rd_slot.pair = pair_arr[ptr_q];

  // R6: legally spaced commands never land on a pending slot
  a_r6_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!vld_vec[idx_lo] && !vld_vec[idx_hi]));
endmodule

// File: rtl/pfs_drive.sv
`timescale 1ns/1ps
// Output register: splits the due beat pair across the two half-cycles
// and forms the edge-aligned strobe level.
module pfs_drive (
  input  logic                        clk,
  input  logic                        rst_n,
  input  pfs_pkg::slot_t              rd_slot,
  output logic [pfs_pkg::BEAT_W-1:0]  dq_rise,
  output logic [pfs_pkg::BEAT_W-1:0]  dq_fall,
  output logic                        dq_vld,
  output logic [pfs_pkg::LANES-1:0]   rdqs_hi
);
  import pfs_pkg::*;

  logic [BEAT_W-1:0] rise_d, fall_d;
  logic [LANES-1:0]  qs_d;

  always_comb begin
    rise_d = '0;
    fall_d = '0;
    qs_d   = '0;
    if (rd_slot.vld) begin
      rise_d = rd_slot.pair[BEAT_W-1:0];
      fall_d = rd_slot.pair[HALF_W-1:BEAT_W];
      qs_d   = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_vld  <= 1'b0;
      dq_rise <= '0;
      dq_fall <= '0;
      rdqs_hi <= '0;
    end else begin
      dq_vld  <= rd_slot.vld;
      dq_rise <= rise_d;
      dq_fall <= fall_d;
      rdqs_hi <= qs_d;
    end
  end

  // R4: a data burst never lasts a single cycle
  a_r4_pair_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_vld) |=> dq_vld);

  // R8 / R7: idle cycles drive neither data nor strobe
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_vld |-> (dq_rise == '0 && dq_fall == '0 && rdqs_hi == '0));
endmodule

// File: rtl/prefetch_rd_serializer.sv
`timescale 1ns/1ps
module prefetch_rd_serializer #(
  parameter int MIN_CL = 7,
  parameter int MAX_CL = 17,
  parameter int CLW    = $clog2(MAX_CL + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_cmd,
  input  logic         rd_bl8,
  input  logic [CLW-1:0] cas_lat,
  input  logic [127:0] core_word,
  output logic [31:0]  dq_rise,
  output logic [31:0]  dq_fall,
  output logic         dq_vld,
  output logic [3:0]   rdqs_hi
);
  import pfs_pkg::*;

  // furthest write lands MAX_CL+2 slots ahead of the pointer
  localparam int PW    = $clog2(MAX_CL + 4);
  localparam int SLOTS = 1 << PW;

  logic              wr_en;
  logic [PW-1:0]     wr_dly;
  logic [WORD_W-1:0] wr_word;
  slot_t             rd_slot;

  pfs_cmd #(.MIN_CL(MIN_CL), .MAX_CL(MAX_CL), .CLW(CLW), .PW(PW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_bl8(rd_bl8),
    .cas_lat(cas_lat), .core_word(core_word),
    .wr_en(wr_en), .wr_dly(wr_dly), .wr_word(wr_word)
  );

  pfs_ring #(.PW(PW), .SLOTS(SLOTS)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dly(wr_dly),
    .wr_word(wr_word), .rd_slot(rd_slot)
  );

  pfs_drive u_drive (
    .clk(clk), .rst_n(rst_n), .rd_slot(rd_slot),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_vld(dq_vld), .rdqs_hi(rdqs_hi)
  );
endmodule

// File: tb/test_prefetch_rd_serializer.sv
`timescale 1ns/1ps
module test_prefetch_rd_serializer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         rd_cmd, rd_bl8;
  logic [4:0]   cas_lat;
  logic [127:0] core_word;
  logic [31:0]  dq_rise, dq_fall;
  logic         dq_vld;
  logic [3:0]   rdqs_hi;

  int    checks = 0;
  int    failures = 0;
  int    edge_cnt = 0;
  bit    chk_on = 1'b0;
  string phase = "R1 reset";

  logic        exp_v [64];
  logic [31:0] exp_r [64];
  logic [31:0] exp_f [64];

  always #2.5 clk = ~clk;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  prefetch_rd_serializer i_prefetch_rd_serializer (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_bl8(rd_bl8),
    .cas_lat(cas_lat), .core_word(core_word),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_vld(dq_vld), .rdqs_hi(rdqs_hi)
  );

  task automatic check(input bit ok, input string what,
                       input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, got, want);
    end
  endtask

  // R9 clamp as the requirement states it
  function automatic int eff_cl(input int c);
    if (c < 7)  return 7;
    if (c > 17) return 17;
    return c;
  endfunction

  // R3 beat order: low 64 bits at edge e, high 64 bits at edge e+1
  task automatic put_word(input int e, input logic [127:0] w);
    int i0, i1;
    i0 = e % 64;
    i1 = (e + 1) % 64;
    exp_v[i0] = 1'b1; exp_r[i0] = w[31:0];  exp_f[i0] = w[63:32];
    exp_v[i1] = 1'b1; exp_r[i1] = w[95:64]; exp_f[i1] = w[127:96];
  endtask

  function automatic logic [127:0] rnd_word();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Called at a negedge; takes two cycles. poke raises rd_cmd and alters
  // cas_lat in the second-word cycle (R10, R11).
  task automatic issue(input bit bl8, input int cl, input logic [127:0] w0,
                       input logic [127:0] w1, input bit poke);
    int e0;
    e0 = edge_cnt + 1;
    rd_cmd = 1'b1; rd_bl8 = bl8; cas_lat = 5'(cl); core_word = w0;
    put_word(e0 + eff_cl(cl), w0);
    if (bl8) put_word(e0 + eff_cl(cl) + 2, w1);
    @(negedge clk);
    rd_cmd = poke; rd_bl8 = 1'b1; cas_lat = poke ? 5'd3 : 5'(cl); core_word = w1;
    @(negedge clk);
    rd_cmd = 1'b0; rd_bl8 = 1'b0; core_word = rnd_word();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-cycle comparison against the predicted schedule
  always @(negedge clk) begin
    if (chk_on) begin
      int i;
      i = edge_cnt % 64;
      check(dq_vld == exp_v[i], "R2/R4/R5/R6 valid", 32'(dq_vld), 32'(exp_v[i]));
      check(rdqs_hi == {4{exp_v[i]}}, "R7 strobe", 32'(rdqs_hi), 32'({4{exp_v[i]}}));
      if (exp_v[i]) begin
        check(dq_rise == exp_r[i], "R3 rise beat", dq_rise, exp_r[i]);
        check(dq_fall == exp_f[i], "R3 fall beat", dq_fall, exp_f[i]);
      end else begin
        check(dq_rise == 32'd0, "R8 idle rise", dq_rise, 32'd0);
        check(dq_fall == 32'd0, "R8 idle fall", dq_fall, 32'd0);
      end
      exp_v[i] = 1'b0; exp_r[i] = '0; exp_f[i] = '0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin
      exp_v[i] = 1'b0; exp_r[i] = '0; exp_f[i] = '0;
    end
    rst_n = 1'b0; rd_cmd = 1'b0; rd_bl8 = 1'b0; cas_lat = 5'd7; core_word = '0;
    idle(3);
    // R1: outputs quiet in reset
    check(dq_vld == 1'b0, "R1 valid", 32'(dq_vld), 0);
    check(rdqs_hi == 4'd0, "R1 strobe", 32'(rdqs_hi), 0);
    check(dq_rise == 32'd0, "R1 rise", dq_rise, 0);
    check(dq_fall == 32'd0, "R1 fall", dq_fall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1'b1;
    idle(4);

    phase = "R2 latency 7";
    issue(0, 7, 128'h44444444_33333333_22222222_11111111, '0, 0);
    idle(25);
    phase = "R2 latency 17";
    issue(0, 17, rnd_word(), rnd_word(), 0);
    idle(25);
    phase = "R3 R4 burst of 4";
    issue(0, 11, 128'hdddd0004_cccc0003_bbbb0002_aaaa0001, '0, 0);
    idle(25);
    phase = "R5 burst of 8";
    issue(1, 9, rnd_word(), rnd_word(), 0);
    idle(25);
    phase = "R6 back-to-back burst of 4";
    for (int k = 0; k < 4; k++) issue(0, 10, rnd_word(), rnd_word(), 0);
    idle(25);
    phase = "R6 back-to-back burst of 8";
    for (int k = 0; k < 3; k++) begin
      issue(1, 8, rnd_word(), rnd_word(), 0);
      idle(2);
    end
    idle(25);
    phase = "R9 clamp low";
    issue(0, 0, rnd_word(), rnd_word(), 0);
    idle(25);
    phase = "R9 clamp high";
    issue(1, 31, rnd_word(), rnd_word(), 0);
    idle(25);
    phase = "R10 R11 ignored command and latency change";
    issue(1, 12, rnd_word(), rnd_word(), 1);
    idle(25);

    phase = "random mix";
    for (int t = 0; t < 40; t++) begin
      int cl, n;
      cl = int'($urandom_range(4, 20));
      n  = int'($urandom_range(1, 6));
      for (int k = 0; k < n; k++) begin
        bit b8;
        b8 = 1'($urandom_range(0, 1));
        issue(b8, cl, rnd_word(), rnd_word(), 0);
        if (b8) idle(2);
        idle(int'($urandom_range(0, 1)) * 2);
      end
      idle(24);
    end

    chk_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule